// File: doc/BRIEF.md
# DMA Queue Doorbell Register Slice

This block is the register slice for a single queue of a DMA engine. Software reaches it over a plain 32-bit register bus with word addresses. It presents two values to the descriptor fetch engine: how many descriptors are waiting, and whether the queue may fetch. The fetch engine signals each descriptor it takes with a one-cycle pulse, and the waiting count drops by one for each pulse.

The doorbell works by increment. Each write adds its value to the waiting count; it never loads an absolute tail index. The slice also holds the following:

- a queue configuration word with separate prefetch-enable and scheduling-enable bits;
- a rate-limit mask whose top bit holds the queue in an internal pause;
- a software-control word whose reset bit discards all pending work;
- a ring size register;
- a ring base register that refuses misaligned addresses.

Three sticky status flags record rejected or overflowing doorbells and refused base writes.

Top module: `qdb_top`

## Requirements
- R1: After reset the registers read as follows: configuration (word 0x0) is 0x0300_0000, rate-limit mask (word 0x1) is 3'b111, status (word 0x5) is 0, pending count (word 0x6) is 0, and ring size (word 0x4) is the DEF_RING_SIZE parameter. The `pendingCount` output is 0.
- R2: A bus write to word 0xE (byte offset 0x38) adds the written value to the pending count. The new count appears on `pendingCount` and at word 0x6 one cycle after the write.
- R3: A doorbell write of 0, or of any value above the current ring size (compared as a full 32-bit unsigned number), is rejected. It leaves the pending count unchanged and sets status bit 0.
- R4: If an accepted doorbell would push the pending count above the ring size, the count is clamped to the ring size and status bit 1 is set. Every status flag stays set until a queue reset.
- R5: A `fetchTake` pulse lowers the pending count by one. It is ignored when the count is zero. In a cycle that has both a pulse and a doorbell, the pulse is applied first and the doorbell value is then added.
- R6: `fetchEnable` is high only while configuration bit 24 (prefetch) and bit 25 (scheduling) are both 1 and rate-mask bit 2 (internal pause) is 0. Clearing either enable bit, or setting the pause bit, stops fetching from the next cycle.
- R7: A write to word 0x2 with bit 8 set resets the queue. In that cycle it clears the pending count and all status bits, and any `fetchTake` pulse is ignored. A write to word 0x2 with bit 8 clear has no effect. Word 0x2 reads as 0.
- R8: A write to the ring base (word 0x3) is accepted only if the base and the base plus ring size × 16 both have their low 8 bits equal to zero. Otherwise the stored base is kept and status bit 2 is set.
- R9: The configuration word, the 3-bit rate mask, the ring base and the ring size (SIZE_W bits) read back as written. Unmapped words and the doorbell word read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| fetchTake | input | 1 | Fetch engine consumed one descriptor |
| pendingCount | output | SIZE_W | Descriptors waiting to be fetched |
| fetchEnable | output | 1 | Queue is allowed to fetch |

## Verification
The bench builds the slice with SIZE_W = 8 and DEF_RING_SIZE = 32. With a 32-entry ring, saturation and drain to zero take only a few dozen cycles. An 8-bit count field also means doorbell values such as 300, which do not fit in the count, reach the full-width rejection compare. Rewriting the ring size to 33 at run time brings the alignment check on the end address into reach, with a base that is itself aligned.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CFG      = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_RATE     = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_SWCTRL   = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_BASE     = 4'h3;
  localparam logic [ADDR_W-1:0] OFF_SIZE     = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 4'h5;
  localparam logic [ADDR_W-1:0] OFF_PEND     = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_DOORBELL = 4'hE;  // byte 0x38

  localparam logic [31:0] CFG_RESET  = 32'h0300_0000;
  localparam logic [2:0]  RATE_RESET = 3'b111;

  localparam int BIT_PREFETCH = 24;
  localparam int BIT_SCHED    = 25;
  localparam int BIT_QRESET   = 8;
  localparam int BIT_INTPAUSE = 2;

  // status bit positions
  localparam int ST_REJECT = 0;
  localparam int ST_OVER   = 1;
  localparam int ST_ALIGN  = 2;

  typedef struct packed {
    logic        doorbellWr;
    logic        baseWr;
    logic        queueReset;
    logic [31:0] wrData;
  } qdbStrobe_t;
endpackage

// File: rtl/qdb_ctrl.sv
module qdb_ctrl
  import qdb_pkg::*;
#(
  parameter int SIZE_W        = 16,
  parameter int DEF_RING_SIZE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output qdbStrobe_t        strobe,
  output logic [SIZE_W-1:0] ringSize,
  output logic              fetchEnable,
  input  logic [SIZE_W-1:0] pendCount,
  input  logic [2:0]        errFlags,
  input  logic [31:0]       ringBase
);
  logic [31:0] cfgReg;
  logic [2:0]  rateReg;

  always_comb begin
    strobe.doorbellWr = busWrEn && (busAddr == OFF_DOORBELL);
    strobe.baseWr     = busWrEn && (busAddr == OFF_BASE);
    strobe.queueReset = busWrEn && (busAddr == OFF_SWCTRL) && busWrData[BIT_QRESET];
    strobe.wrData     = busWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= CFG_RESET;
      rateReg  <= RATE_RESET;
      ringSize <= SIZE_W'(DEF_RING_SIZE);
    end else if (busWrEn) begin
      case (busAddr)
        OFF_CFG:  cfgReg   <= busWrData;
        OFF_RATE: rateReg  <= busWrData[2:0];
        OFF_SIZE: ringSize <= busWrData[SIZE_W-1:0];
        default:  ;
      endcase
    end
  end

  assign fetchEnable = cfgReg[BIT_PREFETCH] && cfgReg[BIT_SCHED] && !rateReg[BIT_INTPAUSE];

  always_comb begin
    case (busAddr)
      OFF_CFG:    busRdData = cfgReg;
      OFF_RATE:   busRdData = {29'b0, rateReg};
      OFF_BASE:   busRdData = ringBase;
      OFF_SIZE:   busRdData = 32'(ringSize);
      OFF_STATUS: busRdData = {29'b0, errFlags};
      OFF_PEND:   busRdData = 32'(pendCount);
      default:    busRdData = 32'b0;
    endcase
  end

  // R6: dropping either enable bit gates fetching on the next cycle
  p_cfg_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == OFF_CFG && busWrData[BIT_SCHED:BIT_PREFETCH] != 2'b11 |=> !fetchEnable);
  // R6: setting the internal pause bit stops fetching
  p_pause_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == OFF_RATE && busWrData[BIT_INTPAUSE] |=> !fetchEnable);
endmodule

// File: rtl/qdb_datapath.sv
module qdb_datapath
  import qdb_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qdbStrobe_t        strobe,
  input  logic              fetchTake,
  input  logic [SIZE_W-1:0] ringSize,
  output logic [SIZE_W-1:0] pendCount,
  output logic [2:0]        errFlags,
  output logic [31:0]       ringBase
);
  logic [SIZE_W-1:0] afterTake;
  logic [SIZE_W:0]   sumW;
  logic [31:0]       endAddr;
  logic              dbBad, dbOver, alignBad;

  always_comb begin
    afterTake = pendCount - ((fetchTake && pendCount != '0) ? SIZE_W'(1) : SIZE_W'(0));
    dbBad     = (strobe.wrData == 32'b0) || (strobe.wrData > 32'(ringSize));
    sumW      = {1'b0, afterTake} + {1'b0, strobe.wrData[SIZE_W-1:0]};
    dbOver    = sumW > {1'b0, ringSize};
    endAddr   = strobe.wrData + (32'(ringSize) << 4);
    alignBad  = (strobe.wrData[7:0] != 8'b0) || (endAddr[7:0] != 8'b0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCount <= '0;
      errFlags  <= '0;
      ringBase  <= '0;
    end else if (strobe.queueReset) begin
      pendCount <= '0;
      errFlags  <= '0;
    end else begin
      pendCount <= afterTake;
      if (strobe.doorbellWr) begin
        if (dbBad) begin
          errFlags[ST_REJECT] <= 1'b1;
        end else if (dbOver) begin
          pendCount         <= ringSize;
          errFlags[ST_OVER] <= 1'b1;
        end else begin
          pendCount <= sumW[SIZE_W-1:0];
        end
      end
      if (strobe.baseWr) begin
        if (alignBad) errFlags[ST_ALIGN] <= 1'b1;
        else          ringBase <= strobe.wrData;
      end
    end
  end

  // R5: an empty queue stays empty without a doorbell
  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    pendCount == '0 && !strobe.doorbellWr |=> pendCount == '0);
  // R5: a consume pulse takes exactly one descriptor
  p_consume_r5: assert property (@(posedge clk) disable iff (!rstN)
    pendCount != '0 && fetchTake && !strobe.doorbellWr && !strobe.queueReset
    |=> pendCount == $past(pendCount) - SIZE_W'(1));
  // R3: a zero doorbell is flagged
  p_reject_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doorbellWr && strobe.wrData == 32'b0 && !strobe.queueReset |=> errFlags[ST_REJECT]);
  // R4: overflow flag is sticky
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    errFlags[ST_OVER] && !strobe.queueReset |=> errFlags[ST_OVER]);
  // R4: an overflowing doorbell clamps to the ring size
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doorbellWr && !dbBad && dbOver && !strobe.queueReset |=> pendCount == $past(ringSize));
  // R7: queue reset empties the queue and clears status
  p_qreset_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.queueReset |=> pendCount == '0 && errFlags == 3'b0);
endmodule

// File: rtl/qdb_top.sv
module qdb_top
  import qdb_pkg::*;
#(
  parameter int SIZE_W        = 16,
  parameter int DEF_RING_SIZE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              fetchTake,
  output logic [SIZE_W-1:0] pendingCount,
  output logic              fetchEnable
);
  qdbStrobe_t        strobe;
  logic [SIZE_W-1:0] ringSize;
  logic [2:0]        errFlags;
  logic [31:0]       ringBase;

  qdb_ctrl #(.SIZE_W(SIZE_W), .DEF_RING_SIZE(DEF_RING_SIZE)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .strobe(strobe),
    .ringSize(ringSize), .fetchEnable(fetchEnable), .pendCount(pendingCount),
    .errFlags(errFlags), .ringBase(ringBase)
  );

  qdb_datapath #(.SIZE_W(SIZE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchTake(fetchTake),
    .ringSize(ringSize), .pendCount(pendingCount), .errFlags(errFlags),
    .ringBase(ringBase)
  );
endmodule

// File: tb/tb_qdb_top.sv
module tb_qdb_top;
  localparam int SW = 8;
  localparam int DEFSZ = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [31:0] busWrData = 32'b0;
  logic [31:0] busRdData;
  logic fetchTake = 1'b0;
  logic [SW-1:0] pendingCount;
  logic fetchEnable;

  int nCheck = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // reference model state
  int mPend = 0;
  int mSize = DEFSZ;
  logic [31:0] mCfg = 32'h0300_0000;
  logic [2:0] mRate = 3'b111;
  logic [31:0] mBase = 32'b0;
  logic [2:0] mErr = 3'b0;

  always #2 clk = ~clk;  // 250 MHz

  qdb_top #(.SIZE_W(SW), .DEF_RING_SIZE(DEFSZ)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .fetchTake(fetchTake),
    .pendingCount(pendingCount), .fetchEnable(fetchEnable)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic we, input logic [3:0] a, input logic [31:0] d, input logic tk);
    int p;
    logic [31:0] e;
    if (we && a == 4'h2 && d[8]) begin
      mPend = 0;
      mErr = 3'b0;
    end else begin
      p = mPend;
      if (tk && p > 0) p--;
      if (we && a == 4'hE) begin
        if (d == 32'b0 || longint'(d) > longint'(mSize)) mErr[0] = 1'b1;
        else if (p + int'(d) > mSize) begin p = mSize; mErr[1] = 1'b1; end
        else p = p + int'(d);
      end
      mPend = p;
      if (we && a == 4'h3) begin
        e = d + 32'(mSize * 16);
        if (d[7:0] != 8'b0 || e[7:0] != 8'b0) mErr[2] = 1'b1;
        else mBase = d;
      end
    end
    if (we && a == 4'h0) mCfg = d;
    if (we && a == 4'h1) mRate = d[2:0];
    if (we && a == 4'h4) mSize = int'(d[SW-1:0]);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic tk, input string tag);
    logic en;
    busWrEn = we; busAddr = a; busWrData = d; fetchTake = tk;
    @(posedge clk);
    modelStep(we, a, d, tk);
    @(negedge clk);
    busWrEn = 1'b0; fetchTake = 1'b0;
    en = mCfg[24] && mCfg[25] && !mRate[2];
    check({tag, " pending"}, 32'(pendingCount), 32'(mPend));
    check({tag, " enable"}, {31'b0, fetchEnable}, {31'b0, en});
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    busWrEn = 1'b0; busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nCheck++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(4'h0, 32'h0300_0000, "R1 cfg");
    rd(4'h1, 32'h7, "R1 rate");
    rd(4'h5, 32'h0, "R1 status");
    rd(4'h6, 32'h0, "R1 pending reg");
    rd(4'h4, 32'(DEFSZ), "R1 size");
    check("R1 pending out", 32'(pendingCount), 32'h0);
    check("R6 paused at reset", {31'b0, fetchEnable}, 32'h0);
    // R2 doorbell adds
    tick(1'b1, 4'hE, 32'd5, 1'b0, "R2 add 5");
    tick(1'b1, 4'hE, 32'd3, 1'b0, "R2 add 3");
    rd(4'h6, 32'd8, "R2 pending reg");
    rd(4'hE, 32'h0, "R9 doorbell reads zero");
    // R3 rejects
    tick(1'b1, 4'hE, 32'd0, 1'b0, "R3 zero");
    rd(4'h5, 32'h1, "R3 status");
    tick(1'b1, 4'hE, 32'd33, 1'b0, "R3 above size");
    tick(1'b1, 4'hE, 32'd300, 1'b0, "R3 wide value");
    // R7 control word without reset bit has no effect
    tick(1'b1, 4'h2, 32'h0000_00FF, 1'b0, "R7 no reset bit");
    rd(4'h5, 32'h1, "R7 status kept");
    rd(4'h2, 32'h0, "R7 swctrl reads zero");
    tick(1'b1, 4'h2, 32'h0000_0100, 1'b1, "R7 queue reset");
    rd(4'h5, 32'h0, "R7 status cleared");
    // R4 saturation
    tick(1'b1, 4'hE, 32'd30, 1'b0, "R4 add 30");
    tick(1'b1, 4'hE, 32'd10, 1'b0, "R4 saturate");
    rd(4'h5, 32'h2, "R4 overflow flag");
    tick(1'b1, 4'hE, 32'd32, 1'b0, "R4 full add at top");
    // R5 consume, take with doorbell
    tick(1'b1, 4'hE, 32'd1, 1'b1, "R5 take then add");
    for (int i = 0; i < 35; i++) tick(1'b0, 4'h0, 32'b0, 1'b1, "R5 drain");
    tick(1'b1, 4'hE, 32'd4, 1'b1, "R5 take at zero with add");
    tick(1'b0, 4'h0, 32'b0, 1'b1, "R5 take");
    rd(4'h5, 32'h2, "R4 still sticky");
    // R6 enables
    tick(1'b1, 4'h1, 32'h3, 1'b0, "R6 unpause");
    tick(1'b1, 4'h0, 32'h0100_0000, 1'b0, "R6 prefetch only");
    tick(1'b1, 4'h0, 32'h0200_0000, 1'b0, "R6 sched only");
    tick(1'b1, 4'h0, 32'h0300_00A5, 1'b0, "R6 both");
    rd(4'h0, 32'h0300_00A5, "R9 cfg readback");
    tick(1'b1, 4'h1, 32'hFFFF_FFFC, 1'b0, "R6 pause again");
    rd(4'h1, 32'h4, "R9 rate readback");
    // R8 alignment
    tick(1'b1, 4'h3, 32'h0000_1000, 1'b0, "R8 aligned");
    rd(4'h3, 32'h0000_1000, "R8 base stored");
    tick(1'b1, 4'h3, 32'h0000_2010, 1'b0, "R8 misaligned base");
    rd(4'h3, 32'h0000_1000, "R8 base kept");
    rd(4'h5, 32'h6, "R8 align flag");
    tick(1'b1, 4'h4, 32'd33, 1'b0, "R9 size write");
    rd(4'h4, 32'd33, "R9 size readback");
    tick(1'b1, 4'h3, 32'h0000_2000, 1'b0, "R8 end misaligned");
    rd(4'h3, 32'h0000_1000, "R8 base kept end");
    tick(1'b1, 4'hE, 32'd33, 1'b0, "R3 new size accepts 33");
    rd(4'h7, 32'h0, "R9 unmapped");
    finished = 1'b1;
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end
endmodule